// File: doc/BRIEF.md
# PWM Time-Base Counter

This block is the timing heart of one pulse-width modulation channel pair. A 16-bit counter sweeps between zero and a programmable period. It counts up, counts down, counts up then down, or holds. Downstream compare and action logic uses the count value, the current direction and two one-cycle event strobes. One strobe marks the count reaching zero and the other marks it reaching the period.

Software programs the block through a single write port that has two addresses. Address 0 holds a 16-bit control word and address 1 holds the period. The control word sets the count mode and the period load policy. It also sets the run/stop policy and two divide codes. The divide codes feed a two-stage prescaler, which turns the system clock into the counter's advance tick. The period can be written straight to the working copy, or it can be staged in a holding copy that moves across only when the counter wraps to zero. That second option lets a running waveform change period without a glitch.

Top module: `pwm_timebase`

## Requirements
- R1: After a synchronous reset the control word, both period copies and the count are zero and `dir_up_o` is 1. With that control word the counter stays at 0 and raises no event until it is programmed.
- R2: The control word's bits 12:10 (code n) and bits 9:7 (code m) set the advance interval to 2^n × (m = 0 ? 1 : 2m) clock cycles, measured from the cycle after the last control write. In a cycle without an advance tick the count holds.
- R3: Count mode 00 (control bits 1:0) counts up by one per tick. From a count at or above the working period it wraps to 0. `dir_up_o` reads 1.
- R4: Count mode 01 counts down by one per tick. From 0 it reloads the working period. `dir_up_o` reads 0.
- R5: Count mode 10 counts up to the working period, then down to 0, then up again. The turning points follow the sequence P-1, P, P-1 and 1, 0, 1. `dir_up_o` is 1 while rising and 0 while falling.
- R6: Count mode 11 freezes the count and the direction and raises no events.
- R7: `zero_evt_o` and `prd_evt_o` are single-cycle pulses. They appear in the same cycle as an advanced count equal to 0, or equal to the working period that was in force when the count advanced.
- R8: With control bit 3 = 0, a period write updates only the holding copy. The working period takes the holding value at the clock edge where the counter advances to 0.
- R9: With control bit 3 = 1, a period write updates the working period at the next clock edge.
- R10: Run code 00 (control bits 15:14) stops the counter at the next tick. The count holds its value.
- R11: Run code 01 lets the counter advance only while the count is nonzero. The counter runs to the end of its cycle and halts at 0.
- R12: Run codes 10 and 11 let the counter run freely.
- R13: Every control write restarts the prescaler. Control writes repeated more often than the advance interval keep the count from advancing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the control word, 1 the period |
| wr_data | input | CNT_W | Write data. The control word uses bits 15:0 |
| count_o | output | CNT_W | Current count |
| dir_up_o | output | 1 | 1 while counting up, 0 while counting down |
| zero_evt_o | output | 1 | One-cycle pulse when the count reaches 0 |
| prd_evt_o | output | 1 | One-cycle pulse when the count reaches the working period |

## Verification
The embedded properties assume that the control word changes only through the write port. They also assume that the prescaler is cleared in the same edge that changes its codes, so the divide counters never start above their terminal values. The bench drives every update through single one-cycle writes made away from the clock edge, and it never writes the registers any other way. Up-down sweeps always run with a nonzero period, because a zero period turns the direction at every tick and gives no meaningful waveform. The bench's reference model nevertheless follows the same rule if that case occurs.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;

  localparam int CTRL_W     = 16;
  localparam int CODE_W     = 3;
  localparam int MODE_LSB   = 0;
  localparam int IMM_BIT    = 3;
  localparam int FINE_LSB   = 7;
  localparam int COARSE_LSB = 10;
  localparam int RUN_LSB    = 14;

  typedef enum logic [1:0] {
    MODE_UP     = 2'b00,
    MODE_DOWN   = 2'b01,
    MODE_UPDOWN = 2'b10,
    MODE_HOLD   = 2'b11
  } count_mode_e;

  typedef enum logic [1:0] {
    RUN_HALT    = 2'b00,
    RUN_TO_ZERO = 2'b01,
    RUN_FREE_A  = 2'b10,
    RUN_FREE_B  = 2'b11
  } run_mode_e;

endpackage

// File: rtl/ptb_regs.sv
module ptb_regs
  import pwm_timebase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              reload_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              ctrl_wr_o,
  output logic [CNT_W-1:0]  prd_o
);

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  hold_q;
  logic [CNT_W-1:0]  work_q;
  logic              prd_wr;

  assign ctrl_wr_o = wr_en && !wr_addr;
  assign prd_wr    = wr_en && wr_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      hold_q <= '0;
      work_q <= '0;
    end else begin
      if (ctrl_wr_o) ctrl_q <= wr_data[CTRL_W-1:0];
      if (prd_wr) hold_q <= wr_data;
      if (prd_wr && ctrl_q[IMM_BIT]) work_q <= wr_data;
      else if (reload_i && !ctrl_q[IMM_BIT]) work_q <= hold_q;
    end
  end

  assign ctrl_o = ctrl_q;
  assign prd_o  = work_q;

  // R8: staged mode, working period moves only at a wrap to zero
  assert_shadow_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[IMM_BIT] && !reload_i) |=> $stable(work_q));

  // R9: direct mode, written value lands in the working period
  assert_direct_load_R9: assert property (@(posedge clk) disable iff (rst)
    (prd_wr && ctrl_q[IMM_BIT]) |=> (work_q == $past(wr_data)));

endmodule

// File: rtl/ptb_prescaler.sv
module ptb_prescaler
  import pwm_timebase_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [CODE_W-1:0] coarse_code,
  input  logic [CODE_W-1:0] fine_code,
  output logic              tick_o
);

  localparam int COARSE_CW = (1 << CODE_W) - 1;
  localparam int FINE_CW   = CODE_W + 1;

  logic [COARSE_CW-1:0] coarse_q, coarse_last;
  logic [FINE_CW-1:0]   fine_q, fine_last;
  logic                 fine_end, coarse_end;

  // terminal value of the power-of-two stage: n low ones
  for (genvar i = 0; i < COARSE_CW; i++) begin : g_mask
    assign coarse_last[i] = (32'(coarse_code) > i);
  end

  assign fine_last  = (fine_code == '0) ? '0 : ({fine_code, 1'b0} - FINE_CW'(1));
  assign fine_end   = (fine_q == fine_last);
  assign coarse_end = (coarse_q == coarse_last);
  assign tick_o     = fine_end && coarse_end;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fine_q   <= '0;
      coarse_q <= '0;
    end else if (fine_end) begin
      fine_q <= '0;
      if (coarse_end) coarse_q <= '0;
      else            coarse_q <= coarse_q + COARSE_CW'(1);
    end else begin
      fine_q <= fine_q + FINE_CW'(1);
    end
  end

  // R2: after a tick both stages start over
  assert_tick_restarts_R2: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> (fine_q == '0 && coarse_q == '0));

  // R13: a control write clears the divide chain
  assert_clear_restarts_R13: assert property (@(posedge clk) disable iff (rst)
    clr |=> (fine_q == '0 && coarse_q == '0));

  // R2: fast stage never passes its terminal value
  assert_fine_bounded_R2: assert property (@(posedge clk) disable iff (rst)
    fine_q <= fine_last);

endmodule

// File: rtl/ptb_counter.sv
module ptb_counter
  import pwm_timebase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  count_mode_e      mode_i,
  input  run_mode_e        run_i,
  input  logic [CNT_W-1:0] prd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_up_o,
  output logic             zero_evt_o,
  output logic             prd_evt_o,
  output logic             reload_o
);

  logic [CNT_W-1:0] cnt_q, nxt_cnt;
  logic             dir_q, nxt_dir;
  logic             zero_q, prd_q;
  logic             step_ok;
  logic             run_allow;

  always_comb begin
    unique case (run_i)
      RUN_HALT:    run_allow = 1'b0;
      RUN_TO_ZERO: run_allow = (cnt_q != '0);
      default:     run_allow = 1'b1;
    endcase
  end

  assign step_ok = tick_i && (mode_i != MODE_HOLD) && run_allow;

  always_comb begin
    nxt_cnt = cnt_q;
    nxt_dir = dir_q;
    unique case (mode_i)
      MODE_UP: begin
        nxt_dir = 1'b1;
        if (step_ok) nxt_cnt = (cnt_q >= prd_i) ? '0 : cnt_q + CNT_W'(1);
      end
      MODE_DOWN: begin
        nxt_dir = 1'b0;
        if (step_ok) nxt_cnt = (cnt_q == '0) ? prd_i : cnt_q - CNT_W'(1);
      end
      MODE_UPDOWN: begin
        if (step_ok) begin
          if (dir_q) begin
            if (cnt_q >= prd_i) begin
              nxt_dir = 1'b0;
              nxt_cnt = (cnt_q == '0) ? '0 : cnt_q - CNT_W'(1);
            end else begin
              nxt_cnt = cnt_q + CNT_W'(1);
            end
          end else begin
            if (cnt_q == '0) begin
              nxt_dir = 1'b1;
              nxt_cnt = (prd_i == '0) ? '0 : CNT_W'(1);
            end else begin
              nxt_cnt = cnt_q - CNT_W'(1);
            end
          end
        end
      end
      default: begin
        nxt_cnt = cnt_q;
        nxt_dir = dir_q;
      end
    endcase
  end

  assign reload_o = step_ok && (nxt_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      dir_q  <= 1'b1;
      zero_q <= 1'b0;
      prd_q  <= 1'b0;
    end else begin
      cnt_q  <= nxt_cnt;
      dir_q  <= nxt_dir;
      zero_q <= step_ok && (nxt_cnt == '0);
      prd_q  <= step_ok && (nxt_cnt == prd_i);
    end
  end

  assign cnt_o      = cnt_q;
  assign dir_up_o   = dir_q;
  assign zero_evt_o = zero_q;
  assign prd_evt_o  = prd_q;

  // R2: no tick, no movement
  assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(cnt_q));

  // R6: hold mode freezes count and direction, no events
  assert_freeze_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_HOLD) |=> ($stable(cnt_q) && $stable(dir_q) && !zero_q && !prd_q));

  // R7: zero strobe only alongside a zero count
  assert_zero_event_R7: assert property (@(posedge clk) disable iff (rst)
    zero_q |-> (cnt_q == '0));

  // R10: halt code stops the counter
  assert_stop_now_R10: assert property (@(posedge clk) disable iff (rst)
    (run_i == RUN_HALT) |=> $stable(cnt_q));

  // R11: run-to-zero stays parked once at zero
  assert_parked_at_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (run_i == RUN_TO_ZERO && cnt_q == '0) |=> (cnt_q == '0));

  // R3: up mode always reports rising direction
  assert_up_direction_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_UP) |=> dir_q);

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_timebase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_up_o,
  output logic             zero_evt_o,
  output logic             prd_evt_o
);

  logic [CTRL_W-1:0] ctrl;
  logic              ctrl_wr;
  logic [CNT_W-1:0]  prd_work;
  logic              tick;
  logic              reload;

  ptb_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .reload_i  (reload),
    .ctrl_o    (ctrl),
    .ctrl_wr_o (ctrl_wr),
    .prd_o     (prd_work)
  );

  ptb_prescaler u_psc (
    .clk         (clk),
    .rst         (rst),
    .clr         (ctrl_wr),
    .coarse_code (ctrl[COARSE_LSB +: CODE_W]),
    .fine_code   (ctrl[FINE_LSB +: CODE_W]),
    .tick_o      (tick)
  );

  ptb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick),
    .mode_i     (count_mode_e'(ctrl[MODE_LSB +: 2])),
    .run_i      (run_mode_e'(ctrl[RUN_LSB +: 2])),
    .prd_i      (prd_work),
    .cnt_o      (count_o),
    .dir_up_o   (dir_up_o),
    .zero_evt_o (zero_evt_o),
    .prd_evt_o  (prd_evt_o),
    .reload_o   (reload)
  );

endmodule

// File: tb/pwm_timebase_test.sv
module pwm_timebase_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] count_o;
  logic        dir_up_o, zero_evt_o, prd_evt_o;

  int checks = 0;
  int failures = 0;
  bit compare_on = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  pwm_timebase #(.CNT_W(16)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count_o(count_o), .dir_up_o(dir_up_o), .zero_evt_o(zero_evt_o), .prd_evt_o(prd_evt_o)
  );

  // behavioural reference state
  int m_ctrl, m_hold, m_work, m_cnt, m_dir, m_zev, m_pev, m_pos;

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 0; m_hold = 0; m_work = 0; m_cnt = 0;
      m_dir = 1; m_zev = 0; m_pev = 0; m_pos = 0;
    end else begin
      int n, m, interval, mode, run, nc, nd;
      bit tick, go;
      n = (m_ctrl >> 10) & 7;
      m = (m_ctrl >> 7) & 7;
      interval = (1 << n) * ((m == 0) ? 1 : 2 * m);
      mode = m_ctrl & 3;
      run = (m_ctrl >> 14) & 3;
      tick = (m_pos == interval - 1);
      go = tick && (mode != 3) && ((run >= 2) || (run == 1 && m_cnt != 0));
      nc = m_cnt; nd = m_dir;
      if (mode == 0) begin
        nd = 1;
        if (go) nc = (m_cnt >= m_work) ? 0 : m_cnt + 1;
      end else if (mode == 1) begin
        nd = 0;
        if (go) nc = (m_cnt == 0) ? m_work : m_cnt - 1;
      end else if (mode == 2 && go) begin
        if (m_dir == 1) begin
          if (m_cnt >= m_work) begin nd = 0; nc = (m_cnt == 0) ? 0 : m_cnt - 1; end
          else nc = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin nd = 1; nc = (m_work == 0) ? 0 : 1; end
          else nc = m_cnt - 1;
        end
      end
      m_zev = (go && nc == 0) ? 1 : 0;
      m_pev = (go && nc == m_work) ? 1 : 0;
      if (wr_en && wr_addr && ((m_ctrl >> 3) & 1)) m_work = wr_data;
      else if (go && nc == 0 && !((m_ctrl >> 3) & 1)) m_work = m_hold;
      if (wr_en && wr_addr) m_hold = wr_data;
      m_cnt = nc; m_dir = nd;
      if (wr_en && !wr_addr) begin m_ctrl = wr_data; m_pos = 0; end
      else m_pos = tick ? 0 : m_pos + 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (compare_on && !rst) begin
      chk(cur_req, count_o, m_cnt);
      chk(cur_req, dir_up_o, m_dir);
      chk("R7", zero_evt_o, m_zev);
      chk("R7", prd_evt_o, m_pev);
    end
  end

  task automatic wr(bit addr, int data);
    wr_en = 1'b1; wr_addr = addr; wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    wait_cyc(10);
    // R1: reset state, stays parked
    chk("R1", count_o, 0);
    chk("R1", dir_up_o, 1);
    chk("R1", zero_evt_o, 0);
    compare_on = 1;

    cur_req = "R9";  wr(0, 16'h0008); wr(1, 5);
    cur_req = "R3";  wr(0, 16'hC008); wait_cyc(30);
    cur_req = "R9";  wr(1, 7); wait_cyc(20);
    cur_req = "R4";  wr(0, 16'hC009); wait_cyc(30);
    cur_req = "R5";  wr(0, 16'hC00A); wait_cyc(40);

    cur_req = "R6";  wr(0, 16'hC00B); held = count_o; wait_cyc(10);
    chk("R6", count_o, held);

    cur_req = "R12"; wr(0, 16'h8008); wait_cyc(20);

    cur_req = "R10"; wr(0, 16'h0008); held = count_o; wait_cyc(10);
    chk("R10", count_o, held);

    cur_req = "R8";  wr(0, 16'hC000); wr(1, 3); wait_cyc(40);

    cur_req = "R11"; wr(0, 16'h4000); wait_cyc(30);
    chk("R11", count_o, 0);

    cur_req = "R2";  wr(1, 4);
    wr(0, 16'hC000 | (2 << 10) | (3 << 7)); wait_cyc(300);
    wr(0, 16'hC002 | (7 << 10) | (7 << 7)); wait_cyc(6000);
    wr(0, 16'hC001 | (3 << 10)); wait_cyc(120);

    cur_req = "R13"; wr(0, 16'hC088); held = count_o;
    repeat (10) wr(0, 16'hC088);
    chk("R13", count_o, held);
    wait_cyc(10);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule